// File: doc/BRIEF.md
# Instruction Prefetch Queue with Bus Arbitration

This block is the front end of a bus interface unit. It keeps a small byte-wide instruction queue topped up by running 16-bit word fetch cycles on a simple request/acknowledge memory bus. An execution-side consumer takes instruction bytes one at a time from the head of the queue. The consumer never drives the bus itself. Its data reads and writes arrive on a separate request port, and this block places them on the same bus, sharing it with its own prefetch cycles.

Arbitration does not preempt. A fetch that is already on the bus always runs to completion before a pending data access starts. When the block is free to choose the next cycle, a pending data access wins over prefetch. Prefetch starts only when the queue has room for a whole word. A flush input empties the queue at once and redirects fetching to a new address. If a fetch is in flight when the flush arrives, that fetch finishes on the bus, but its data is thrown away.

Top module: `ifq_busfront`

## Requirements
- R1: After synchronous reset, no bus cycle is active, the queue is empty (`pop_valid` low), `ex_done` is low and the next fetch address is 0.
- R2: The queue holds at most six bytes. Bytes leave in the order they were fetched, and within one fetched word the byte at the even address (bits 7:0 of `mem_rdata`) is enqueued before the byte at the odd address (bits 15:8).
- R3: A new prefetch cycle starts only when at least two queue bytes are free and no flush is present in that clock. With five or six bytes held, the bus stays idle.
- R4: When the block is choosing its next bus cycle and `ex_req` is high, it starts the data access (with `ex_addr`, `ex_we`, `ex_wdata`) instead of a prefetch.
- R5: A prefetch cycle in progress when `ex_req` rises completes and its bytes are enqueued before the data access is put on the bus.
- R6: A data access ends with a one-clock `ex_done` pulse in the clock after the acknowledge. For a read, `ex_rdata` then holds the word memory returned. For a write, `mem_wdata` carries `ex_wdata` with `mem_we` high.
- R7: Once `mem_req` is raised, it stays high with stable `mem_addr` and `mem_we` until the clock in which `mem_ack` is high. It is low in the following clock.
- R8: Fetches are issued at even word addresses, and the fetch address advances by 2 after each completed fetch. When the fetch address is odd, only the upper byte of the word is enqueued, and fetching continues at the next even address.
- R9: `flush` empties the queue by the next clock and loads `flush_addr` as the fetch address. A fetch in flight during the flush, including one acknowledged in the same clock, enqueues nothing.
- R10: `pop_valid` is high exactly when the queue is non-empty. A pop with `pop_take` on an empty queue has no effect, and a pop and an enqueue in the same clock leave the occupancy correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue and redirect fetching |
| flush_addr | input | ADDR_W | New fetch address loaded on flush |
| pop_take | input | 1 | Consumer takes the head byte this clock |
| pop_valid | output | 1 | Head byte is valid |
| pop_data | output | 8 | Head byte of the queue |
| ex_req | input | 1 | Data access request, held until `ex_done` is seen |
| ex_we | input | 1 | 1 = write, 0 = read |
| ex_addr | input | ADDR_W | Data access address |
| ex_wdata | input | 16 | Write data |
| ex_rdata | output | 16 | Read data, valid with `ex_done` |
| ex_done | output | 1 | One-clock completion pulse |
| mem_req | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data, valid with `mem_ack` |
| mem_ack | input | 1 | Bus cycle completes this clock |

## Verification
The hardest cases to reach are the ones where two events overlap with a running fetch: a data request arriving partway through a fetch, and a flush landing in each clock of a fetch, including the acknowledge clock itself. The bench waits for a prefetch cycle to begin and then injects the request or the flush after a delay of zero to five clocks, so every position within the four-clock bus cycle is covered. A behavioural byte-queue model, keyed on the fetch address, then catches any byte that was lost, duplicated or wrongly kept.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_FETCH = 2'd1,
        BUS_DATA  = 2'd2,
        BUS_DONE  = 2'd3
    } bus_state_e;

    // Bytes to append to the queue in one clock; b0 goes in first.
    typedef struct packed {
        logic [1:0]        n;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
    } enq_t;

    // Select the byte lanes of a landed fetch word.
    function automatic enq_t lane_pick(input logic [WORD_W-1:0] word,
                                       input logic odd_start,
                                       input logic keep);
        enq_t e;
        e.b1 = word[WORD_W-1:BYTE_W];
        e.b0 = odd_start ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];
        if (!keep)
            e.n = 2'd0;
        else if (odd_start)
            e.n = 2'd1;
        else
            e.n = 2'd2;
        return e;
    endfunction

endpackage

// File: rtl/ifq_bytefifo.sv
module ifq_bytefifo
    import ifq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  enq_t              enq,
    input  logic              pop_req,
    output logic              pop_valid,
    output logic [BYTE_W-1:0] pop_byte,
    output logic [CNT_W-1:0]  count
);

    logic [BYTE_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  rd_q;
    logic [PTR_W-1:0]  wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pop_fire;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                              input logic [1:0] k);
        int unsigned s;
        s = {{(32-PTR_W){1'b0}}, p} + {30'd0, k};
        if (s >= DEPTH)
            s = s - DEPTH;
        return s[PTR_W-1:0];
    endfunction

    assign pop_fire  = pop_req && (cnt_q != '0);
    assign pop_valid = (cnt_q != '0);
    assign pop_byte  = slot_q[rd_q];
    assign count     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= step(wr_q, enq.n);
            rd_q  <= pop_fire ? step(rd_q, 2'd1) : rd_q;
            cnt_q <= cnt_q + CNT_W'(enq.n) - CNT_W'(pop_fire);
        end
    end

    // Storage needs no reset: occupancy alone says which slots are live.
    always_ff @(posedge clk) begin
        if (!rst && !clear) begin
            if (enq.n != 2'd0)
                slot_q[wr_q] <= enq.b0;
            if (enq.n == 2'd2)
                slot_q[step(wr_q, 2'd1)] <= enq.b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (!clear && enq.n != 2'd0) |->
            ((32'(cnt_q) + 32'(enq.n) - 32'(pop_fire)) <= DEPTH)); // R2

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clear |=> !pop_valid); // R9

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (!pop_valid && pop_req && enq.n == 2'd0 && !clear) |=> !pop_valid); // R10

endmodule

// File: rtl/ifq_busarb.sv
module ifq_busarb
    import ifq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DEPTH      = 6,
    parameter int REFILL_MIN = 2,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic [CNT_W-1:0]  q_count,
    input  logic              ex_req,
    input  logic              ex_we,
    input  logic [ADDR_W-1:0] ex_addr,
    input  logic [WORD_W-1:0] ex_wdata,
    output logic [WORD_W-1:0] ex_rdata,
    output logic              ex_done,
    output logic              pf_keep,
    output logic              pf_odd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    bus_state_e        st_q;
    logic [ADDR_W-1:0] fa_q;
    logic [ADDR_W-1:0] baddr_q;
    logic              bwe_q;
    logic [WORD_W-1:0] bwd_q;
    logic [WORD_W-1:0] rd_q;
    logic              drop_q;
    logic              odd_q;
    logic [CNT_W-1:0]  free;
    logic              room;
    logic              fetch_land;

    assign free       = CNT_W'(DEPTH) - q_count;
    assign room       = (free >= CNT_W'(REFILL_MIN));
    assign fetch_land = (st_q == BUS_FETCH) && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= BUS_IDLE;
            fa_q    <= '0;
            baddr_q <= '0;
            bwe_q   <= 1'b0;
            bwd_q   <= '0;
            rd_q    <= '0;
            drop_q  <= 1'b0;
            odd_q   <= 1'b0;
        end else begin
            case (st_q)
                BUS_IDLE: begin
                    if (ex_req) begin
                        st_q    <= BUS_DATA;
                        baddr_q <= ex_addr;
                        bwe_q   <= ex_we;
                        bwd_q   <= ex_wdata;
                    end else if (room && !flush) begin
                        st_q    <= BUS_FETCH;
                        baddr_q <= {fa_q[ADDR_W-1:1], 1'b0};
                        odd_q   <= fa_q[0];
                        bwe_q   <= 1'b0;
                        drop_q  <= 1'b0;
                    end
                end
                BUS_FETCH: begin
                    if (mem_ack) begin
                        st_q <= BUS_IDLE;
                        if (!drop_q && !flush)
                            fa_q <= baddr_q + ADDR_W'(2);
                    end else if (flush) begin
                        drop_q <= 1'b1;
                    end
                end
                BUS_DATA: begin
                    if (mem_ack) begin
                        st_q <= BUS_DONE;
                        rd_q <= mem_rdata;
                    end
                end
                BUS_DONE: st_q <= BUS_IDLE;
                default:  st_q <= BUS_IDLE;
            endcase
            if (flush)
                fa_q <= flush_addr;
        end
    end

    assign pf_keep   = fetch_land && !drop_q && !flush;
    assign pf_odd    = odd_q;
    assign mem_req   = (st_q == BUS_FETCH) || (st_q == BUS_DATA);
    assign mem_we    = (st_q == BUS_DATA) && bwe_q;
    assign mem_addr  = baddr_q;
    assign mem_wdata = bwd_q;
    assign ex_done   = (st_q == BUS_DONE);
    assign ex_rdata  = rd_q;

    AST_FETCH_ROOM: assert property (@(posedge clk) disable iff (rst)
        (st_q == BUS_FETCH && $past(st_q) == BUS_IDLE) |-> ($past(room) && !$past(flush))); // R3

    AST_EX_FIRST: assert property (@(posedge clk) disable iff (rst)
        (st_q == BUS_IDLE && ex_req) |=> (st_q == BUS_DATA)); // R4

    AST_FETCH_FINISH: assert property (@(posedge clk) disable iff (rst)
        (st_q == BUS_FETCH && !mem_ack) |=> (st_q == BUS_FETCH)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ex_done |=> !ex_done); // R6

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7

    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> !mem_req); // R7

    AST_EVEN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (st_q == BUS_FETCH) |-> !mem_addr[0]); // R8

endmodule

// File: rtl/ifq_busfront.sv
module ifq_busfront
    import ifq_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int DEPTH      = 6,
    parameter int REFILL_MIN = 2,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              pop_take,
    output logic              pop_valid,
    output logic [7:0]        pop_data,
    input  logic              ex_req,
    input  logic              ex_we,
    input  logic [ADDR_W-1:0] ex_addr,
    input  logic [15:0]       ex_wdata,
    output logic [15:0]       ex_rdata,
    output logic              ex_done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack
);

    logic [CNT_W-1:0] q_count;
    logic             pf_keep;
    logic             pf_odd;
    enq_t             enq;

    assign enq = lane_pick(mem_rdata, pf_odd, pf_keep);

    ifq_busarb #(
        .ADDR_W     (ADDR_W),
        .DEPTH      (DEPTH),
        .REFILL_MIN (REFILL_MIN)
    ) u_arb (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .flush_addr (flush_addr),
        .q_count    (q_count),
        .ex_req     (ex_req),
        .ex_we      (ex_we),
        .ex_addr    (ex_addr),
        .ex_wdata   (ex_wdata),
        .ex_rdata   (ex_rdata),
        .ex_done    (ex_done),
        .pf_keep    (pf_keep),
        .pf_odd     (pf_odd),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack)
    );

    ifq_bytefifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clear     (flush),
        .enq       (enq),
        .pop_req   (pop_take),
        .pop_valid (pop_valid),
        .pop_byte  (pop_data),
        .count     (q_count)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req && !pop_valid && !ex_done)); // R1

endmodule

// File: tb/ifq_busfront_bench.sv
module ifq_busfront_bench;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          flush = 1'b0;
    logic [AW-1:0] flush_addr = '0;
    logic          pop_take = 1'b0;
    logic          pop_valid;
    logic [7:0]    pop_data;
    logic          ex_req = 1'b0;
    logic          ex_we = 1'b0;
    logic [AW-1:0] ex_addr = '0;
    logic [15:0]   ex_wdata = '0;
    logic [15:0]   ex_rdata;
    logic          ex_done;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = '0;
    logic          mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ifq_busfront u_ifq_busfront (
        .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
        .pop_take(pop_take), .pop_valid(pop_valid), .pop_data(pop_data),
        .ex_req(ex_req), .ex_we(ex_we), .ex_addr(ex_addr), .ex_wdata(ex_wdata),
        .ex_rdata(ex_rdata), .ex_done(ex_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [7:0] bval(input logic [AW-1:0] a);
        return 8'(a * 7 + (a >> 8)) ^ 8'h3C;
    endfunction

    function automatic logic [15:0] wval(input logic [AW-1:0] a);
        logic [AW-1:0] e;
        e = {a[AW-1:1], 1'b0};
        return {bval(e + 1), bval(e)};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory: acknowledge in the fourth clock of each bus cycle.
    int bcnt = 0;
    always @(posedge clk) begin
        #1;
        if (rst || !mem_req) begin
            bcnt    = 0;
            mem_ack = 1'b0;
        end else begin
            bcnt++;
            mem_ack   = (bcnt == 4);
            mem_rdata = wval(mem_addr);
        end
    end

    // Behavioural reference: byte queue plus expected fetch address.
    logic [7:0]    mq[$];
    logic [AW-1:0] maddr = '0;
    bit mdrop = 0, in_fetch = 0, in_data = 0, req_seen = 0, exreq_last = 0;
    int prev_cnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            mq.delete();
            maddr = '0; mdrop = 0; in_fetch = 0; in_data = 0;
            req_seen = 0; exreq_last = 0; prev_cnt = 0;
        end else begin
            int pre;
            bit land;
            pre = mq.size();
            chk(pop_valid == (pre != 0), "R10 valid vs occupancy", pop_valid, pre != 0);
            if (pre != 0 && pop_valid)
                chk(pop_data == mq[0], "R2 byte order", pop_data, mq[0]);
            if (mem_req && !req_seen) begin
                if (exreq_last) begin
                    in_data = 1;
                    chk(mem_addr == ex_addr, "R4 data access address", mem_addr, ex_addr);
                    chk(mem_we == ex_we, "R4 data access direction", mem_we, ex_we);
                end else begin
                    in_fetch = 1;
                    chk(mem_addr == {maddr[AW-1:1], 1'b0}, "R8 fetch address", mem_addr,
                        {maddr[AW-1:1], 1'b0});
                    chk(6 - prev_cnt >= 2, "R3 free bytes at fetch start", 6 - prev_cnt, 2);
                    chk(!mem_we, "R8 fetch is read", mem_we, 0);
                end
            end
            if (mem_req && mem_ack && in_fetch && ex_req)
                chk(!mem_we && mem_addr == {maddr[AW-1:1], 1'b0},
                    "R5 fetch completes before data access", mem_addr, {maddr[AW-1:1], 1'b0});
            if (mem_req && mem_ack && in_data && ex_we)
                chk(mem_wdata == ex_wdata && mem_we, "R6 write data", mem_wdata, ex_wdata);
            land = mem_req && mem_ack && in_fetch;
            if (flush) begin
                mq.delete();
                maddr = flush_addr;
                mdrop = in_fetch && !mem_ack;
            end else begin
                if (pop_take && pre != 0) void'(mq.pop_front());
                if (land) begin
                    if (!mdrop) begin
                        if (maddr[0]) begin
                            mq.push_back(bval(maddr));
                            maddr = maddr + 1;
                        end else begin
                            mq.push_back(bval(maddr));
                            mq.push_back(bval(maddr + 1));
                            maddr = maddr + 2;
                        end
                    end
                    mdrop = 0;
                end
            end
            if (mem_ack) begin in_fetch = 0; in_data = 0; end
            req_seen   = mem_req && !mem_ack;
            prev_cnt   = pre;
            exreq_last = ex_req;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_fetch_start();
        do tick(1); while (mem_req);
        do tick(1); while (!mem_req);
    endtask

    task automatic do_flush(input logic [AW-1:0] a);
        flush = 1'b1; flush_addr = a;
        tick(1);
        flush = 1'b0;
        @(negedge clk);
        chk(!pop_valid, "R9 queue empty after flush", pop_valid, 0);
        tick(0);
        #1;
    endtask

    task automatic ex_op(input bit we, input logic [AW-1:0] a, input logic [15:0] d);
        ex_we = we; ex_addr = a; ex_wdata = d; ex_req = 1'b1;
        do @(negedge clk); while (!ex_done);
        if (!we)
            chk(ex_rdata == wval(a), "R6 read data", ex_rdata, wval(a));
        @(posedge clk); #1;
        ex_req = 1'b0;
        @(negedge clk);
        chk(!ex_done, "R6 done is one clock", ex_done, 0);
        @(posedge clk); #1;
    endtask

    initial begin
        tick(3);
        chk(!pop_valid, "R1 queue empty in reset", pop_valid, 0);
        chk(!mem_req, "R1 bus idle in reset", mem_req, 0);
        chk(!ex_done, "R1 no done in reset", ex_done, 0);
        rst = 1'b0;

        // Fill with no consumer; full queue must leave the bus idle.
        tick(40);
        for (int i = 0; i < 20; i++) begin
            chk(!mem_req, "R3 no fetch with full queue", mem_req, 0);
            tick(1);
        end
        // Empty pop attempt after drain: run consumer.
        pop_take = 1'b1;
        tick(30);

        // Odd redirect with alternating consumer.
        do_flush(20'h00203);
        for (int i = 0; i < 40; i++) begin
            pop_take = i[0];
            tick(1);
        end
        pop_take = 1'b1;

        // Data accesses injected at each offset within a fetch.
        for (int i = 0; i < 6; i++) begin
            wait_fetch_start();
            tick(i);
            ex_op(i[0], 20'h08000 + AW'(4 * i), 16'hA500 + 16'(i));
        end
        // Data access when idle with room.
        ex_op(1'b0, 20'h08100, 16'h0);

        // Flush at each offset within a fetch, even and odd targets.
        for (int i = 0; i < 6; i++) begin
            wait_fetch_start();
            tick(i);
            do_flush(20'h00300 + AW'(16 * i) + AW'(i % 2));
            tick(12);
        end

        // Occupancy five: one free byte must not start a fetch.
        pop_take = 1'b0;
        tick(40);
        pop_take = 1'b1;
        tick(1);
        pop_take = 1'b0;
        for (int i = 0; i < 20; i++) begin
            chk(!mem_req, "R3 no fetch with one free byte", mem_req, 0);
            tick(1);
        end
        pop_take = 1'b1;
        tick(1);
        pop_take = 1'b0;
        tick(2);
        chk(mem_req, "R3 fetch starts with two free bytes", mem_req, 1);
        pop_take = 1'b1;
        tick(30);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule